// File: doc/BRIEF.md
# Chained DMA Descriptor Loader

This block serves one DMA channel that works through a linked chain of transfer descriptors in memory. When the transfer sequencer asks for a new transfer, the loader takes the channel's descriptor pointer and reads four consecutive words from memory. It then writes their contents into the channel registers: selected control bits, the total-size field, the source and destination addresses, and the new descriptor pointer. It also reports whether another descriptor follows the current one.

If the channel is not in chained mode, the loader performs no memory reads. It clears the "more descriptors follow" flag and acknowledges the start request at once. When a chain reaches its final termination and size writeback is enabled, the loader writes the remaining word count back into the total-size field of the size register.

The memory read port holds one request at a time. The request stays high with a stable address until the memory returns a data-valid pulse, so any read latency is accepted. Each register update appears as a one-cycle write-enable pulse with its data, one cycle after the word that carries it returns.

Top module: `dma_desc_loader`

## Requirements
- R1: A chained fetch reads the words at pointer+0x0, +0x4, +0x8 and +0xC in that order. Each address is held, with the request high, until `mem_rvalid_i` is seen for it.
- R2: `busy_o` is high from the cycle after an accepted chained start until the cycle in which the fourth word returns. `done_o` is a single-cycle pulse in the cycle after the fourth word returns, with `busy_o` already low.
- R3: One cycle after the control word (offset 0x0) returns, `ctl_we_o` and `tot_we_o` pulse together. `ctl_bits_o` then equals control bits [19:16] (increment-source, increment-destination, source-select, destination-select, MSB first), and `tot_o` equals control bits [SW-1:0].
- R4: Control-word bit 20 marks the end of the list. After the control word is loaded, `more_desc_o` is 1 when that bit is 0, and 0 when that bit is 1.
- R5: One cycle after the words at offsets 0x4 and 0x8 return, `a0_we_o`/`a0_o` and `a1_we_o`/`a1_o` respectively carry them.
- R6: `cur_desc_o` holds the pointer captured at the accepted chained start. One cycle after the word at offset 0xC returns, `desc_we_o` pulses with `desc_o` equal to that word.
- R7: A start with `chain_mode_i` low issues no memory request, keeps `busy_o` low, clears `more_desc_o`, and pulses `done_o` in the next cycle.
- R8: A start while a fetch is in progress is ignored. The address sequence and `cur_desc_o` keep the first pointer.
- R9: `term_i` with `wb_en_i` high while idle gives, in the next cycle, a `tot_we_o` pulse with `tot_o` = total − count. The result is 0 when count ≥ total.
- R10: `term_i` with `wb_en_i` low, or `term_i` while `busy_o` is high, gives no `tot_we_o` in the next cycle.
- R11: After reset, `busy_o`, `done_o`, `mem_req_o`, `more_desc_o`, every write enable and `cur_desc_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request from the transfer sequencer |
| chain_mode_i | input | 1 | Channel uses descriptor chains |
| desc_ptr_i | input | AW | Current descriptor pointer register |
| busy_o | output | 1 | Descriptor fetch in progress |
| done_o | output | 1 | Start request completed (pulse) |
| more_desc_o | output | 1 | Another descriptor follows when done |
| cur_desc_o | output | AW | Address of the descriptor being used |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory read address |
| mem_rvalid_i | input | 1 | Read data valid; completes the request |
| mem_rdata_i | input | AW | Read data |
| ctl_we_o | output | 1 | Write enable for CSR copy bits |
| ctl_bits_o | output | 4 | Increment/select bits for the CSR |
| tot_we_o | output | 1 | Write enable for the total-size field |
| tot_o | output | SW | Total-size value |
| a0_we_o | output | 1 | Write enable for source address |
| a0_o | output | AW | Source address |
| a1_we_o | output | 1 | Write enable for destination address |
| a1_o | output | AW | Destination address |
| desc_we_o | output | 1 | Write enable for descriptor pointer |
| desc_o | output | AW | Next descriptor pointer |
| term_i | input | 1 | Final termination of the transfer |
| wb_en_i | input | 1 | Size writeback and chained mode both set |
| xfer_total_i | input | SW | Total words of the transfer |
| xfer_count_i | input | SW | Words already transferred |

## Verification
The bench uses the default parameters: a 32-bit address and data width and a 12-bit size field. With a full-width address, a descriptor placed at 0xFFFFFFF0 can be checked so that all four offsets stay correct at the top of the address space. With a 12-bit size field, the total-size bits sit below the copied control bits and the end-of-list bit, so a control word with all size bits set still shows that the fields do not overlap. The same 12-bit width allows writeback cases with count below, equal to and above the total, where the saturating result is exercised.

// File: rtl/dll_pkg.sv
`timescale 1ns/1ps
package dll_pkg;
    // control word layout of a descriptor
    localparam int EOL_BIT = 20;
    localparam int CTL_LSB = 16;
    localparam int CTL_W   = 4;
    // descriptor shape
    localparam int WORDS   = 4;
    localparam int IDX_W   = $clog2(WORDS);

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } fetch_st_e;
endpackage

// File: rtl/dll_fetch_seq.sv
`timescale 1ns/1ps
module dll_fetch_seq
    import dll_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             chain_i,
    input  logic [AW-1:0]    ptr_i,
    input  logic             rvalid_i,
    output logic             req_o,
    output logic [AW-1:0]    addr_o,
    output logic             busy_o,
    output logic             stb_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             nochain_o,
    output logic             done_o,
    output logic [AW-1:0]    cur_o
);
    typedef struct packed {
        fetch_st_e        st;
        logic [IDX_W-1:0] idx;
        logic [AW-1:0]    base;
        logic [AW-1:0]    cur;
        logic             done;
    } seq_t;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    seq_t s_d, s_q;
    logic accept;

    assign accept = start_i && (s_q.st == ST_IDLE);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (accept) begin
            if (chain_i) begin
                s_d.st   = ST_FETCH;
                s_d.idx  = '0;
                s_d.base = ptr_i;
                s_d.cur  = ptr_i;
            end else begin
                s_d.done = 1'b1;
            end
        end else if ((s_q.st == ST_FETCH) && rvalid_i) begin
            s_d.idx = s_q.idx + 1'b1;
            if (s_q.idx == LAST_IDX) begin
                s_d.st   = ST_IDLE;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o    = (s_q.st == ST_FETCH);
    assign req_o     = busy_o;
    assign addr_o    = s_q.base + AW'({s_q.idx, 2'b00});
    assign stb_o     = busy_o && rvalid_i;
    assign idx_o     = s_q.idx;
    assign nochain_o = accept && !chain_i;
    assign done_o    = s_q.done;
    assign cur_o     = s_q.cur;
endmodule

// File: rtl/dll_unpack.sv
`timescale 1ns/1ps
module dll_unpack
    import dll_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [AW-1:0]    data_i,
    input  logic             nochain_i,
    output logic             ctl_we_o,
    output logic [CTL_W-1:0] ctl_o,
    output logic             tot_we_o,
    output logic [SW-1:0]    tot_o,
    output logic             a0_we_o,
    output logic [AW-1:0]    a0_o,
    output logic             a1_we_o,
    output logic [AW-1:0]    a1_o,
    output logic             nx_we_o,
    output logic [AW-1:0]    nx_o,
    output logic             more_o
);
    typedef struct packed {
        logic             ctl_we;
        logic [CTL_W-1:0] ctl;
        logic             tot_we;
        logic [SW-1:0]    tot;
        logic             a0_we;
        logic [AW-1:0]    a0;
        logic             a1_we;
        logic [AW-1:0]    a1;
        logic             nx_we;
        logic [AW-1:0]    nx;
        logic             more;
    } unp_t;

    unp_t u_d, u_q;

    always_comb begin
        u_d        = u_q;
        u_d.ctl_we = 1'b0;
        u_d.tot_we = 1'b0;
        u_d.a0_we  = 1'b0;
        u_d.a1_we  = 1'b0;
        u_d.nx_we  = 1'b0;
        if (stb_i) begin
            unique case (idx_i)
                IDX_W'(0): begin
                    u_d.ctl_we = 1'b1;
                    u_d.ctl    = data_i[CTL_LSB +: CTL_W];
                    u_d.tot_we = 1'b1;
                    u_d.tot    = data_i[SW-1:0];
                    u_d.more   = !data_i[EOL_BIT];
                end
                IDX_W'(1): begin
                    u_d.a0_we = 1'b1;
                    u_d.a0    = data_i;
                end
                IDX_W'(2): begin
                    u_d.a1_we = 1'b1;
                    u_d.a1    = data_i;
                end
                default: begin
                    u_d.nx_we = 1'b1;
                    u_d.nx    = data_i;
                end
            endcase
        end
        if (nochain_i) begin
            u_d.more = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            u_q <= '0;
        end else begin
            u_q <= u_d;
        end
    end

    assign ctl_we_o = u_q.ctl_we;
    assign ctl_o    = u_q.ctl;
    assign tot_we_o = u_q.tot_we;
    assign tot_o    = u_q.tot;
    assign a0_we_o  = u_q.a0_we;
    assign a0_o     = u_q.a0;
    assign a1_we_o  = u_q.a1_we;
    assign a1_o     = u_q.a1;
    assign nx_we_o  = u_q.nx_we;
    assign nx_o     = u_q.nx;
    assign more_o   = u_q.more;
endmodule

// File: rtl/dll_size_wb.sv
`timescale 1ns/1ps
module dll_size_wb #(
    parameter int SW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          term_i,
    input  logic          wb_en_i,
    input  logic          busy_i,
    input  logic [SW-1:0] total_i,
    input  logic [SW-1:0] count_i,
    output logic          we_o,
    output logic [SW-1:0] val_o
);
    typedef struct packed {
        logic          we;
        logic [SW-1:0] val;
    } wb_t;

    wb_t w_d, w_q;

    always_comb begin
        w_d    = w_q;
        w_d.we = term_i && wb_en_i && !busy_i;
        if (w_d.we) begin
            w_d.val = (count_i >= total_i) ? '0 : (total_i - count_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign we_o  = w_q.we;
    assign val_o = w_q.val;
endmodule

// File: rtl/dma_desc_loader.sv
`timescale 1ns/1ps
module dma_desc_loader
    import dll_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          chain_mode_i,
    input  logic [AW-1:0] desc_ptr_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          more_desc_o,
    output logic [AW-1:0] cur_desc_o,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_rvalid_i,
    input  logic [AW-1:0] mem_rdata_i,
    output logic          ctl_we_o,
    output logic [3:0]    ctl_bits_o,
    output logic          tot_we_o,
    output logic [SW-1:0] tot_o,
    output logic          a0_we_o,
    output logic [AW-1:0] a0_o,
    output logic          a1_we_o,
    output logic [AW-1:0] a1_o,
    output logic          desc_we_o,
    output logic [AW-1:0] desc_o,
    input  logic          term_i,
    input  logic          wb_en_i,
    input  logic [SW-1:0] xfer_total_i,
    input  logic [SW-1:0] xfer_count_i
);
    logic             stb;
    logic [IDX_W-1:0] idx;
    logic             nochain;
    logic             fetch_tot_we;
    logic [SW-1:0]    fetch_tot;
    logic             wb_we;
    logic [SW-1:0]    wb_val;

    dll_fetch_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .chain_i   (chain_mode_i),
        .ptr_i     (desc_ptr_i),
        .rvalid_i  (mem_rvalid_i),
        .req_o     (mem_req_o),
        .addr_o    (mem_addr_o),
        .busy_o    (busy_o),
        .stb_o     (stb),
        .idx_o     (idx),
        .nochain_o (nochain),
        .done_o    (done_o),
        .cur_o     (cur_desc_o)
    );

    dll_unpack #(.AW(AW), .SW(SW)) u_unp (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_i     (stb),
        .idx_i     (idx),
        .data_i    (mem_rdata_i),
        .nochain_i (nochain),
        .ctl_we_o  (ctl_we_o),
        .ctl_o     (ctl_bits_o),
        .tot_we_o  (fetch_tot_we),
        .tot_o     (fetch_tot),
        .a0_we_o   (a0_we_o),
        .a0_o      (a0_o),
        .a1_we_o   (a1_we_o),
        .a1_o      (a1_o),
        .nx_we_o   (desc_we_o),
        .nx_o      (desc_o),
        .more_o    (more_desc_o)
    );

    dll_size_wb #(.SW(SW)) u_wb (
        .clk     (clk),
        .rst_n   (rst_n),
        .term_i  (term_i),
        .wb_en_i (wb_en_i),
        .busy_i  (busy_o),
        .total_i (xfer_total_i),
        .count_i (xfer_count_i),
        .we_o    (wb_we),
        .val_o   (wb_val)
    );

    // writeback is only accepted while idle, so the two sources never coincide
    assign tot_we_o = wb_we || fetch_tot_we;
    assign tot_o    = wb_we ? wb_val : fetch_tot;
endmodule

// File: rtl/dma_desc_loader_chk.sv
`timescale 1ns/1ps
module dma_desc_loader_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          chain_mode_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          more_desc_o,
    input logic          mem_req_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_rvalid_i,
    input logic          ctl_we_o,
    input logic          tot_we_o,
    input logic          term_i,
    input logic          wb_en_i
);
    logic [1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (mem_req_o && mem_rvalid_i) begin
            cnt_q <= cnt_q + 2'd1;
        end
    end

    p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

    p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_rvalid_i && (cnt_q != 2'd3)
        |=> mem_req_o && (mem_addr_o == $past(mem_addr_o) + AW'(4)));

    p_done_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_rvalid_i && (cnt_q == 2'd3) |=> done_o && !busy_o);

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> !done_o);

    p_ctl_with_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we_o |-> tot_we_o);

    p_no_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !chain_mode_i && !busy_o
        |=> done_o && !busy_o && !mem_req_o && !more_desc_o);

    p_no_writeback_r10: assert property (@(posedge clk) disable iff (!rst_n)
        term_i && !wb_en_i && !busy_o |=> !tot_we_o);
endmodule

bind dma_desc_loader dma_desc_loader_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .chain_mode_i (chain_mode_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .more_desc_o  (more_desc_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .ctl_we_o     (ctl_we_o),
    .tot_we_o     (tot_we_o),
    .term_i       (term_i),
    .wb_en_i      (wb_en_i)
);

// File: tb/sim_dma_desc_loader.sv
`timescale 1ns/1ps
module sim_dma_desc_loader;
    localparam int AW = 32;
    localparam int SW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i;
    logic          chain_mode_i;
    logic [AW-1:0] desc_ptr_i;
    logic          busy_o;
    logic          done_o;
    logic          more_desc_o;
    logic [AW-1:0] cur_desc_o;
    logic          mem_req_o;
    logic [AW-1:0] mem_addr_o;
    logic          mem_rvalid_i;
    logic [AW-1:0] mem_rdata_i;
    logic          ctl_we_o;
    logic [3:0]    ctl_bits_o;
    logic          tot_we_o;
    logic [SW-1:0] tot_o;
    logic          a0_we_o;
    logic [AW-1:0] a0_o;
    logic          a1_we_o;
    logic [AW-1:0] a1_o;
    logic          desc_we_o;
    logic [AW-1:0] desc_o;
    logic          term_i;
    logic          wb_en_i;
    logic [SW-1:0] xfer_total_i;
    logic [SW-1:0] xfer_count_i;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dma_desc_loader #(.AW(AW), .SW(SW)) u0 (.*);

    // pointer, control, source, destination, next, latency
    localparam logic [31:0] TBL [4][6] = '{
        '{32'h0000_0100, 32'h000F_0ABC, 32'h1000_0000, 32'h2000_0000, 32'h0000_0140, 32'd0},
        '{32'h0000_0140, 32'h0015_0005, 32'h1000_4000, 32'h2000_8000, 32'h0000_0000, 32'd2},
        '{32'h0000_0200, 32'h000A_0FFF, 32'hDEAD_BEE0, 32'h0BAD_F00C, 32'h0000_0240, 32'd1},
        '{32'hFFFF_FFF0, 32'h0010_0000, 32'hFFFF_FFFC, 32'h0000_0004, 32'h1234_5670, 32'd3}
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic go(logic [31:0] ptr, logic chain);
        @(negedge clk);
        start_i      = 1'b1;
        chain_mode_i = chain;
        desc_ptr_i   = ptr;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic feed(logic [31:0] ptr, logic [31:0] w0, logic [31:0] w1,
                        logic [31:0] w2, logic [31:0] w3, int lat);
        logic [31:0] w [4];
        w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
        for (int i = 0; i < 4; i++) begin
            for (int k = 0; k < lat; k++) begin
                chk("R1 address held while waiting", mem_addr_o, ptr + 32'(4 * i));
                @(negedge clk);
            end
            chk("R1 request high", 32'(mem_req_o), 32'd1);
            chk("R1 word address", mem_addr_o, ptr + 32'(4 * i));
            chk("R2 busy during fetch", 32'(busy_o), 32'd1);
            mem_rvalid_i = 1'b1;
            mem_rdata_i  = w[i];
            @(negedge clk);
            mem_rvalid_i = 1'b0;
            mem_rdata_i  = '0;
            case (i)
                0: begin
                    chk("R3 ctl write enable", 32'(ctl_we_o), 32'd1);
                    chk("R3 ctl bits", 32'(ctl_bits_o), 32'(w0[19:16]));
                    chk("R3 size write enable", 32'(tot_we_o), 32'd1);
                    chk("R3 total size", 32'(tot_o), 32'(w0[SW-1:0]));
                    chk("R4 more descriptors", 32'(more_desc_o), 32'(!w0[20]));
                    chk("R2 no early done", 32'(done_o), 32'd0);
                end
                1: begin
                    chk("R3 ctl pulse ends", 32'(ctl_we_o), 32'd0);
                    chk("R5 a0 write enable", 32'(a0_we_o), 32'd1);
                    chk("R5 a0 value", a0_o, w1);
                end
                2: begin
                    chk("R5 a1 write enable", 32'(a1_we_o), 32'd1);
                    chk("R5 a1 value", a1_o, w2);
                end
                default: begin
                    chk("R6 desc write enable", 32'(desc_we_o), 32'd1);
                    chk("R6 next pointer", desc_o, w3);
                    chk("R6 current descriptor", cur_desc_o, ptr);
                    chk("R2 done pulse", 32'(done_o), 32'd1);
                    chk("R2 busy released", 32'(busy_o), 32'd0);
                end
            endcase
        end
        @(negedge clk);
        chk("R2 done single cycle", 32'(done_o), 32'd0);
        chk("R6 desc pulse ends", 32'(desc_we_o), 32'd0);
        chk("R1 request dropped", 32'(mem_req_o), 32'd0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst_n        = 1'b0;
        start_i      = 1'b0;
        chain_mode_i = 1'b0;
        desc_ptr_i   = '0;
        mem_rvalid_i = 1'b0;
        mem_rdata_i  = '0;
        term_i       = 1'b0;
        wb_en_i      = 1'b0;
        xfer_total_i = '0;
        xfer_count_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 busy", 32'(busy_o), 32'd0);
        chk("R11 done", 32'(done_o), 32'd0);
        chk("R11 request", 32'(mem_req_o), 32'd0);
        chk("R11 more", 32'(more_desc_o), 32'd0);
        chk("R11 enables", 32'({ctl_we_o, tot_we_o, a0_we_o, a1_we_o, desc_we_o}), 32'd0);
        chk("R11 current descriptor", cur_desc_o, 32'd0);

        // table walk: chained fetches
        for (int v = 0; v < 4; v++) begin
            go(TBL[v][0], 1'b1);
            chk("R6 pointer captured at start", cur_desc_o, TBL[v][0]);
            feed(TBL[v][0], TBL[v][1], TBL[v][2], TBL[v][3], TBL[v][4], int'(TBL[v][5]));
        end

        // R7: fetch leaves more=1, then unchained start clears it
        go(32'h0000_0800, 1'b1);
        feed(32'h0000_0800, 32'h0003_0010, 32'h11, 32'h22, 32'h840, 0);
        chk("R4 more set before unchained start", 32'(more_desc_o), 32'd1);
        go(32'h0000_0900, 1'b0);
        chk("R7 done pulse", 32'(done_o), 32'd1);
        chk("R7 busy stays low", 32'(busy_o), 32'd0);
        chk("R7 no request", 32'(mem_req_o), 32'd0);
        chk("R7 more cleared", 32'(more_desc_o), 32'd0);
        @(negedge clk);
        chk("R7 done single cycle", 32'(done_o), 32'd0);

        // R8: start while busy is ignored
        go(32'h0000_0300, 1'b1);
        start_i      = 1'b1;
        chain_mode_i = 1'b1;
        desc_ptr_i   = 32'h0000_0400;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 address keeps first pointer", mem_addr_o, 32'h0000_0300);
        chk("R8 current descriptor unchanged", cur_desc_o, 32'h0000_0300);
        feed(32'h0000_0300, 32'h0011_0001, 32'h33, 32'h44, 32'h0, 1);
        chk("R8 no second fetch", 32'(mem_req_o), 32'd0);

        // R10: termination while busy gives no writeback
        go(32'h0000_0500, 1'b1);
        term_i       = 1'b1;
        wb_en_i      = 1'b1;
        xfer_total_i = 12'd50;
        xfer_count_i = 12'd10;
        @(negedge clk);
        term_i = 1'b0;
        chk("R10 no writeback while busy", 32'(tot_we_o), 32'd0);
        feed(32'h0000_0500, 32'h0010_0020, 32'h55, 32'h66, 32'h0, 0);

        // R9: writeback, normal case
        term_i       = 1'b1;
        wb_en_i      = 1'b1;
        xfer_total_i = 12'd100;
        xfer_count_i = 12'd30;
        @(negedge clk);
        term_i = 1'b0;
        chk("R9 writeback enable", 32'(tot_we_o), 32'd1);
        chk("R9 remaining words", 32'(tot_o), 32'd70);
        @(negedge clk);
        chk("R9 writeback single cycle", 32'(tot_we_o), 32'd0);

        // R9: equal counts
        term_i       = 1'b1;
        xfer_total_i = 12'd40;
        xfer_count_i = 12'd40;
        @(negedge clk);
        term_i = 1'b0;
        chk("R9 equal gives zero", 32'(tot_o), 32'd0);
        chk("R9 equal write enable", 32'(tot_we_o), 32'd1);

        // R9: count above total saturates
        term_i       = 1'b1;
        xfer_total_i = 12'd5;
        xfer_count_i = 12'd9;
        @(negedge clk);
        term_i = 1'b0;
        chk("R9 saturated to zero", 32'(tot_o), 32'd0);
        chk("R9 saturated write enable", 32'(tot_we_o), 32'd1);

        // R10: writeback disabled
        term_i       = 1'b1;
        wb_en_i      = 1'b0;
        xfer_total_i = 12'd100;
        xfer_count_i = 12'd1;
        @(negedge clk);
        term_i = 1'b0;
        chk("R10 no writeback when disabled", 32'(tot_we_o), 32'd0);

        @(negedge clk);
        finish_run();
    end
endmodule